// File: doc/BRIEF.md
# Hybrid Ripple-Lookahead 64-bit Adder

This block adds two 64-bit unsigned operands and a one-bit carry-in and returns a 64-bit sum together with a carry-out. It is purely combinational: there is no clock and no reset, and every output follows the inputs within the same cycle. The block is meant to sit inside a datapath stage whose surrounding registers set the timing.

The operands are cut into sixteen 4-bit slices. Each slice reduces its bits to one slice propagate and one slice generate. A first lookahead level joins four slices into a 16-bit segment. A second lookahead level joins the four segments. Only the carry that enters each slice, at bit positions that are multiples of four, comes from this two-level tree. Inside a slice the carry ripples from bit to bit through a majority function. This keeps the lookahead units small and lightly loaded, and the longest path still ends at the top sum bit.

Top module: `hybrid_cla_adder`

## Requirements
- R1: For every input combination, the 65-bit value {cout, sum} equals a + b + cin.
- R2: Inside a 4-bit slice, bit i+1 receives the majority of a[i], b[i] and the carry into bit i, and sum bit i is a[i] XOR b[i] XOR that carry. A slice whose four bits all propagate passes its incoming carry straight out.
- R3: The carry entering each slice at bit 4k (k = 1..15) comes from the lookahead tree, and it matches the carry that rippled out of slice k-1.
- R4: The carry entering each 16-bit segment at bits 16, 32 and 48 comes from the second lookahead level, built from segment propagate/generate terms and cin, and it matches the carry-out that the first level predicts for the segment below.
- R5: cout is 1 exactly when a + b + cin reaches 2^64. With a all ones, b zero and cin = 1, the carry crosses all 64 bits and gives sum = 0 and cout = 1.
- R6: With a = b = 0 the result is sum = cin and cout = 0. With a = b = 0 and cin = 0 every output is zero.
- R7: A slice's propagate and generate terms are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand, unsigned |
| b | input | 64 | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 63 |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register stages between operands and sum or carry-out. The bench changes the operands on the falling clock edge and reads sum and cout a few nanoseconds later, well before the next rising edge. Each operand pattern therefore has settled before it is compared against a 65-bit behavioural addition worked out in the bench. The stimulus favours carries that start in one slice and run through whole slices and whole segments, so that a wrong slice-boundary or segment-boundary carry shows up at the ports.

// File: rtl/hybrid_cla_pkg.sv
package hybrid_cla_pkg;
  localparam int unsigned DATA_W  = 64;  // operand width
  localparam int unsigned SLICE_W = 4;   // bits per ripple slice
  localparam int unsigned FANIN   = 4;   // children per lookahead unit
  localparam int unsigned NSLICE  = DATA_W / SLICE_W;  // 16
  localparam int unsigned NSEG    = NSLICE / FANIN;    // 4
endpackage

// File: rtl/slice_pg.sv
// Reduces one slice to a slice propagate / slice generate pair.
module slice_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         s_prop,
  output logic         s_gen
);
  logic [W-1:0] bp;
  logic [W-1:0] bg;

  assign bp = op_a ^ op_b;
  assign bg = op_a & op_b;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < int'(W); i++) begin
      acc = bg[i] | (bp[i] & acc);
    end
    s_gen  = acc;
    s_prop = &bp;
  end

  // R7: propagate and generate of one slice exclude each other
  always_comb begin
    if (!$isunknown({s_prop, s_gen})) begin
      a_r7_pg_exclusive: assert (!(s_prop && s_gen))
        else $error("R7: slice propagate and generate both high");
    end
  end
endmodule

// File: rtl/slice_ripple.sv
// Ripples the carry through one slice and forms its sum bits.
module slice_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         c_in,
  output logic [W-1:0] s_out,
  output logic         c_out
);
  logic [W:0] cy;

  assign cy[0] = c_in;

  genvar i;
  generate
    for (i = 0; i < int'(W); i++) begin : g_bit
      assign cy[i+1]  = (op_a[i] & op_b[i]) | (op_a[i] & cy[i]) | (op_b[i] & cy[i]);
      assign s_out[i] = op_a[i] ^ op_b[i] ^ cy[i];
    end
  endgenerate

  assign c_out = cy[W];

  // R2: when every bit propagates, the slice hands its carry through unchanged
  always_comb begin
    if (!$isunknown({op_a, op_b, c_in, c_out})) begin
      if ((op_a ^ op_b) == {W{1'b1}}) begin
        a_r2_pass_through: assert (c_out == c_in)
          else $error("R2: full-propagate slice did not pass carry");
      end
    end
  end
endmodule

// File: rtl/lookahead_unit.sv
// Sum-of-products lookahead over N children: carry into each child,
// carry out of the group, and group propagate / generate.
module lookahead_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] ch_p,
  input  logic [N-1:0] ch_g,
  input  logic         c_in,
  output logic [N-1:0] ch_c,
  output logic         c_out,
  output logic         grp_p,
  output logic         grp_g
);
  logic [N:0] cy;

  always_comb begin
    logic acc;
    logic term;
    for (int j = 0; j <= int'(N); j++) begin
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = ch_g[k];
        for (int m = k + 1; m < j; m++) begin
          term = term & ch_p[m];
        end
        acc = acc | term;
      end
      term = c_in;
      for (int m = 0; m < j; m++) begin
        term = term & ch_p[m];
      end
      cy[j] = acc | term;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      term = ch_g[k];
      for (int m = k + 1; m < int'(N); m++) begin
        term = term & ch_p[m];
      end
      acc = acc | term;
    end
    grp_g = acc;
    grp_p = &ch_p;
  end

  assign ch_c  = cy[N-1:0];
  assign c_out = cy[N];

  // R7: group terms stay exclusive when child terms are
  always_comb begin
    if (!$isunknown({grp_p, grp_g})) begin
      a_r7_group_exclusive: assert (!(grp_p && grp_g))
        else $error("R7: group propagate and generate both high");
    end
  end
endmodule

// File: rtl/hybrid_cla_adder.sv
module hybrid_cla_adder
  import hybrid_cla_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  logic [NSLICE-1:0] sl_p;
  logic [NSLICE-1:0] sl_g;
  logic [NSLICE-1:0] sl_cin;    // carry into each slice, from lookahead
  logic [NSLICE-1:0] sl_rcout;  // carry rippled out of each slice
  logic [NSEG-1:0]   sg_p;
  logic [NSEG-1:0]   sg_g;
  logic [NSEG-1:0]   sg_cin;    // carry into each segment, level two
  logic [NSEG-1:0]   sg_pcout;  // level-one predicted segment carry-out
  logic              top_p;
  logic              top_g;

  genvar s, k;
  generate
    for (k = 0; k < int'(NSLICE); k++) begin : g_slice
      slice_pg #(.W(SLICE_W)) u_pg (
        .op_a   (a[k*SLICE_W +: SLICE_W]),
        .op_b   (b[k*SLICE_W +: SLICE_W]),
        .s_prop (sl_p[k]),
        .s_gen  (sl_g[k])
      );
      slice_ripple #(.W(SLICE_W)) u_rip (
        .op_a  (a[k*SLICE_W +: SLICE_W]),
        .op_b  (b[k*SLICE_W +: SLICE_W]),
        .c_in  (sl_cin[k]),
        .s_out (sum[k*SLICE_W +: SLICE_W]),
        .c_out (sl_rcout[k])
      );
    end

    for (s = 0; s < int'(NSEG); s++) begin : g_seg
      lookahead_unit #(.N(FANIN)) u_la1 (
        .ch_p  (sl_p[s*FANIN +: FANIN]),
        .ch_g  (sl_g[s*FANIN +: FANIN]),
        .c_in  (sg_cin[s]),
        .ch_c  (sl_cin[s*FANIN +: FANIN]),
        .c_out (sg_pcout[s]),
        .grp_p (sg_p[s]),
        .grp_g (sg_g[s])
      );
    end
  endgenerate

  lookahead_unit #(.N(NSEG)) u_la2 (
    .ch_p  (sg_p),
    .ch_g  (sg_g),
    .c_in  (cin),
    .ch_c  (sg_cin),
    .c_out (cout),
    .grp_p (top_p),
    .grp_g (top_g)
  );

  // R3: each predicted slice carry agrees with the ripple out of the slice below
  generate
    for (k = 1; k < int'(NSLICE); k++) begin : g_chk_slice
      always_comb begin
        if (!$isunknown({sl_cin[k], sl_rcout[k-1]})) begin
          a_r3_slice_carry: assert (sl_cin[k] == sl_rcout[k-1])
            else $error("R3: slice %0d lookahead carry disagrees with ripple", k);
        end
      end
    end
    // R4: level-one segment carry-out agrees with level-two segment carry-in
    for (s = 0; s < int'(NSEG) - 1; s++) begin : g_chk_seg
      always_comb begin
        if (!$isunknown({sg_pcout[s], sg_cin[s+1]})) begin
          a_r4_segment_carry: assert (sg_pcout[s] == sg_cin[s+1])
            else $error("R4: segment %0d carry levels disagree", s);
        end
      end
    end
  endgenerate

  // R5: carry-out from the tree agrees with the ripple out of the top slice
  // and with the top-level propagate/generate pair
  always_comb begin
    if (!$isunknown({cout, sl_rcout[NSLICE-1], sg_pcout[NSEG-1], top_p, top_g, cin})) begin
      a_r5_cout_ripple: assert (cout == sl_rcout[NSLICE-1])
        else $error("R5: carry-out disagrees with top slice ripple");
      a_r5_cout_level1: assert (cout == sg_pcout[NSEG-1])
        else $error("R5: carry-out disagrees with level-one prediction");
      a_r5_cout_topterms: assert (cout == (top_g | (top_p & cin)))
        else $error("R5: carry-out disagrees with top propagate/generate");
    end
  end
endmodule

// File: tb/sim_hybrid_cla_adder.sv
`timescale 1ns/1ps
module sim_hybrid_cla_adder;
  localparam int W = 64;

  typedef struct packed {
    logic [W-1:0] va;
    logic [W-1:0] vb;
    logic         vc;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TAB [NVEC] = '{
    '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0},
    '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1},
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1},
    '{64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0},
    '{64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b1},
    '{64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, 1'b0},
    '{64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0},
    '{64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}
  };

  logic         clk;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;
  int           total;
  int           bad;
  bit           done;

  hybrid_cla_adder u0 (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // Drive on the falling edge, read mid-phase: results are due in the same cycle.
  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic tc,
                       input string req);
    logic [W:0] exp;
    @(negedge clk);
    a   = ta;
    b   = tb_;
    cin = tc;
    #2;
    exp = {1'b0, ta} + {1'b0, tb_} + {{W{1'b0}}, tc};
    total++;
    if ({cout, sum} !== exp) begin
      bad++;
      $display("FAIL %s: a=%h b=%h cin=%b got cout=%b sum=%h exp cout=%b sum=%h",
               req, ta, tb_, tc, cout, sum, exp[W], exp[W-1:0]);
    end
  endtask

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    a = '0; b = '0; cin = 1'b0;

    // R6: idle state with zero operands
    @(negedge clk); #2;
    total++;
    if (sum !== '0 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R6: zero inputs got cout=%b sum=%h exp cout=0 sum=0", cout, sum);
    end

    // R1: table walk (covers R5 and R6 entries too)
    for (int i = 0; i < NVEC; i++) begin
      apply(TAB[i].va, TAB[i].vb, TAB[i].vc, "R1");
    end

    // R5: carry runs through all 64 bits from cin
    apply({W{1'b1}}, '0, 1'b1, "R5");
    total++;
    if (cout !== 1'b1 || sum !== '0) begin
      bad++;
      $display("FAIL R5: full chain got cout=%b sum=%h exp cout=1 sum=0", cout, sum);
    end

    // R6: cin alone
    apply('0, '0, 1'b1, "R6");
    total++;
    if (sum !== 64'd1 || cout !== 1'b0) begin
      bad++;
      $display("FAIL R6: cin only got cout=%b sum=%h exp cout=0 sum=1", cout, sum);
    end

    // R3: generate in slice k, propagate through the rest of the word
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] ta;
      logic [W-1:0] tbv;
      ta  = {W{1'b1}} << (4 * k);
      tbv = 64'h1 << (4 * k);
      apply(ta, tbv, 1'b0, "R3");
    end

    // R4: carries crossing each segment boundary
    for (int s = 1; s < 4; s++) begin
      logic [W-1:0] ta;
      ta = (64'h1 << (16 * s)) - 64'h1;
      apply(ta, '0, 1'b1, "R4");
      apply(ta, 64'h1, 1'b0, "R4");
    end

    // R2: in-slice ripple for every bit pair pattern in slice 0 and 7
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] ta;
      logic [W-1:0] tbv;
      ta  = (64'(v & 15) << 28) | 64'(v & 15);
      tbv = (64'(v >> 4) << 28) | 64'(v >> 4);
      apply(ta, tbv, v[0], "R2");
    end

    // R1: random operands
    for (int n = 0; n < 2000; n++) begin
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule